// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command front end of a NOR flash model. A host writes 16-bit words on a write port. The low byte of each word is decoded as a command, or the word is taken as the operand the current command sequence expects. The block tracks which view a read returns: array contents, the status byte, identifier words or query words. It runs single-word program, buffered program and whole-block erase. Any of these can be paused with suspend and continued with resume. An 8-bit status byte reports ready, suspend state and errors.

The cell array is a small register memory. Programming can only clear bits. Each operation's duration is a fixed, parameterised number of cycles. Whenever a sequence is being set up or an operation is running, every read returns the status byte, whatever read view was last selected. Error bits are sticky. While an error bit is set, program and erase sequences are accepted on the bus but change nothing.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the read view is array, every cell reads 0xFFFF and the status byte is 0x80. The status layout is: bit 7 ready (1 = idle), bit 6 erase suspended, bit 5 erase or sequence error, bit 4 program or sequence error, bit 2 program suspended, all other bits 0. In status view the byte appears on rd_data[7:0] with rd_data[15:8] = 0. Asserting reset during an operation abandons it.
- R2: Commands are taken from wr_data[7:0], and the upper byte is ignored. Each of these selects a read view: 0xFF array, 0x70 status, 0x90 identifier and 0x98 query. In identifier view, offset 0 returns MFR_ID, offset 1 returns DEV_ID and other offsets return 0. In query view, offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59, and other offsets return 0.
- R3: The word program sequence is 0x40, then one data write to the target address. After exactly PGM_CYCLES cycles with status bit 7 at 0, the cell holds its old value AND the data. From setup onward, reads return status until 0xFF is written.
- R4: The buffered program sequence is 0xE8 at a block address, then a count N-1 in wr_data[8:0], then N data writes inside that block, then 0xD0 to that block. All N words are then programmed in one PGM_CYCLES busy period.
- R5: A buffered program sequence fails with a sequence error if any of these occurs: a count of BUF_DEPTH or more, a data write outside the block, a confirm word other than 0xD0, or a confirm to another block. The error sets status bits 5 and 4 (bit 7 stays 1), leaves the array unchanged and returns the block to idle.
- R6: The erase sequence is 0x20, then 0xD0 at an address in the block. After ERS_CYCLES cycles every word of that block reads 0xFFFF and other blocks are unchanged. Any other word after 0x20 is a sequence error.
- R7: Writing 0xB0 during an operation suspends it. Status bit 7 then reads 1, and bit 2 (program) or bit 6 (erase) is set. The operation makes no progress while suspended, and array reads are possible after 0xFF.
- R8: Writing 0xD0 while suspended resumes the operation. The suspend bit clears, bit 7 returns to 0, and the operation completes with its remaining cycles.
- R9: Error bits stay set until 0x50 is written. Read view commands do not clear them.
- R10: While status bit 5 or bit 4 is set, program and erase sequences leave the array unchanged and never drop ready.
- R11: While an operation runs, every command other than 0xB0 is ignored, including read view changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Command byte in [7:0], or count or data word |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 16 | Read word, combinational from rd_addr and state |
| ready | output | 1 | High unless a program or erase is running |

## Verification
The bench aims at malformed buffered sequences: an oversize count, stray data outside the block, a wrong confirm word and a confirm to another block. A design that checked only the confirm word would silently program the wrong block or accept an overflowing buffer. Suspend is checked for stalled progress and for the right suspend bit. A design that kept counting while suspended would show programmed or erased cells before resume. A busy length checked to the exact cycle catches off-by-one delays. The locked-out program and the ignored read-array during busy catch designs that clear errors on a view change or let commands leak into a running operation.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W = 6,
  parameter int BLK_W = 3,
  parameter int BUF_DEPTH = 8,
  parameter int PGM_CYCLES = 12,
  parameter int ERS_CYCLES = 30,
  parameter logic [15:0] MFR_ID = 16'h00A5,
  parameter logic [15:0] DEV_ID = 16'h7E21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              ready
);
  localparam int WORDS   = 1 << ADDR_W;
  localparam int BLK_WDS = 1 << BLK_W;
  localparam int BID_W   = ADDR_W - BLK_W;
  localparam int BUF_W   = $clog2(BUF_DEPTH);
  localparam int DLY_MAX = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PSET, S_ESET, S_BSET, S_BLOAD, S_BCONF, S_BUSY, S_SUSP} state_t;
  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_IDENT, M_QUERY} view_t;

  state_t            state;
  view_t             view;
  logic              op_erase;
  logic [BID_W-1:0]  tgt_blk;
  logic [BUF_W-1:0]  nlast, ld_idx;
  logic [CNT_W-1:0]  dly;
  logic              err_e, err_p;
  logic [15:0]       mem   [WORDS];
  logic [ADDR_W-1:0] buf_a [BUF_DEPTH];
  logic [15:0]       buf_d [BUF_DEPTH];

  logic [7:0]       cmd;
  logic [BID_W-1:0] wr_blk;
  logic             locked, busy, susp_p, susp_e, redirect;
  logic [7:0]       status;

  assign cmd      = wr_data[7:0];
  assign wr_blk   = wr_addr[ADDR_W-1:BLK_W];
  assign locked   = err_e | err_p;
  assign busy     = (state == S_BUSY);
  assign susp_p   = (state == S_SUSP) && !op_erase;
  assign susp_e   = (state == S_SUSP) && op_erase;
  assign status   = {~busy, susp_e, err_e, err_p, 1'b0, susp_p, 2'b00};
  assign ready    = ~busy;
  assign redirect = !(state == S_IDLE || state == S_SUSP);

  always_comb begin
    rd_data = 16'h0000;
    if (redirect) rd_data = {8'h00, status};
    else begin
      case (view)
        M_ARRAY:  rd_data = mem[rd_addr];
        M_STATUS: rd_data = {8'h00, status};
        M_IDENT: begin
          if (rd_addr == ADDR_W'(0)) rd_data = MFR_ID;
          else if (rd_addr == ADDR_W'(1)) rd_data = DEV_ID;
        end
        M_QUERY: begin
          if (rd_addr == ADDR_W'(16)) rd_data = 16'h0051;
          else if (rd_addr == ADDR_W'(17)) rd_data = 16'h0052;
          else if (rd_addr == ADDR_W'(18)) rd_data = 16'h0059;
        end
        default: rd_data = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      view     <= M_ARRAY;
      op_erase <= 1'b0;
      tgt_blk  <= '0;
      nlast    <= '0;
      ld_idx   <= '0;
      dly      <= '0;
      err_e    <= 1'b0;
      err_p    <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
      for (int i = 0; i < BUF_DEPTH; i++) begin
        buf_a[i] <= '0;
        buf_d[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE, S_SUSP: if (wr_en) begin
          case (cmd)
            8'hFF: view <= M_ARRAY;
            8'h70: view <= M_STATUS;
            8'h90: view <= M_IDENT;
            8'h98: view <= M_QUERY;
            8'h50: begin
              err_e <= 1'b0;
              err_p <= 1'b0;
            end
            8'h40: if (state == S_IDLE) begin
              state <= S_PSET;
              view  <= M_STATUS;
            end
            8'h20: if (state == S_IDLE) begin
              state <= S_ESET;
              view  <= M_STATUS;
            end
            8'hE8: if (state == S_IDLE) begin
              state   <= S_BSET;
              view    <= M_STATUS;
              tgt_blk <= wr_blk;
            end
            8'hD0: if (state == S_SUSP) begin
              state <= S_BUSY;
              view  <= M_STATUS;
            end
            default: ;
          endcase
        end
        S_PSET: if (wr_en) begin
          buf_a[0] <= wr_addr;
          buf_d[0] <= wr_data;
          nlast    <= '0;
          op_erase <= 1'b0;
          dly      <= CNT_W'(PGM_CYCLES - 1);
          state    <= locked ? S_IDLE : S_BUSY;
        end
        S_ESET: if (wr_en) begin
          if (cmd != 8'hD0) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else begin
            tgt_blk  <= wr_blk;
            op_erase <= 1'b1;
            dly      <= CNT_W'(ERS_CYCLES - 1);
            state    <= locked ? S_IDLE : S_BUSY;
          end
        end
        S_BSET: if (wr_en) begin
          if ({1'b0, wr_data[8:0]} >= 10'(BUF_DEPTH)) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else begin
            nlast  <= wr_data[BUF_W-1:0];
            ld_idx <= '0;
            state  <= S_BLOAD;
          end
        end
        S_BLOAD: if (wr_en) begin
          if (wr_blk != tgt_blk) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else begin
            buf_a[ld_idx] <= wr_addr;
            buf_d[ld_idx] <= wr_data;
            ld_idx        <= ld_idx + 1'b1;
            if (ld_idx == nlast) state <= S_BCONF;
          end
        end
        S_BCONF: if (wr_en) begin
          if (cmd != 8'hD0 || wr_blk != tgt_blk) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else begin
            op_erase <= 1'b0;
            dly      <= CNT_W'(PGM_CYCLES - 1);
            state    <= locked ? S_IDLE : S_BUSY;
          end
        end
        S_BUSY: begin
          if (wr_en && cmd == 8'hB0) begin
            state <= S_SUSP;
            view  <= M_STATUS;
          end else if (dly == '0) begin
            state <= S_IDLE;
            if (op_erase) begin
              for (int i = 0; i < BLK_WDS; i++) mem[{tgt_blk, BLK_W'(i)}] <= 16'hFFFF;
            end else begin
              for (int i = 0; i < BUF_DEPTH; i++)
                if (i <= int'(nlast)) mem[buf_a[i]] <= mem[buf_a[i]] & buf_d[i];
            end
          end else dly <= dly - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  busy_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data == 16'h0000 && !ready));
  // R5
  bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BCONF && wr_en && cmd != 8'hD0) |=> (err_e && err_p && ready && state == S_IDLE));
  // R7
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && cmd == 8'hB0) |=> (state == S_SUSP && ready && rd_data[7]));
  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP) |=> $stable(dly));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_e && !(wr_en && cmd == 8'h50 && (state == S_IDLE || state == S_SUSP))) |=> err_e);
  // R10
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && state == S_PSET && wr_en) |=> (state == S_IDLE && ready));
endmodule

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb_top;
  localparam int AW = 6;
  localparam int PGM = 12;
  localparam int ERS = 30;
  localparam int NV = 59;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OT = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic ready;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(AW), .BLK_W(3), .BUF_DEPTH(8), .PGM_CYCLES(PGM), .ERS_CYCLES(ERS),
    .MFR_ID(16'h00A5), .DEV_ID(16'h7E21)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready));

  // fields: op[45:44] req[43:40] addr[39:32] data[31:16] expect[15:0]
  localparam logic [45:0] VEC [NV] = '{
    {ORD,4'd1,8'h05,16'h0000,16'hFFFF}, // R1 erased after reset
    {OW, 4'd2,8'h05,16'h0070,16'h0000}, // R2
    {ORD,4'd1,8'h00,16'h0000,16'h0080}, // R1 status after reset
    {OW, 4'd2,8'h00,16'h0090,16'h0000},
    {ORD,4'd2,8'h00,16'h0000,16'h00A5},
    {ORD,4'd2,8'h01,16'h0000,16'h7E21},
    {ORD,4'd2,8'h02,16'h0000,16'h0000},
    {OW, 4'd2,8'h00,16'h0098,16'h0000},
    {ORD,4'd2,8'h10,16'h0000,16'h0051},
    {ORD,4'd2,8'h11,16'h0000,16'h0052},
    {ORD,4'd2,8'h12,16'h0000,16'h0059},
    {ORD,4'd2,8'h13,16'h0000,16'h0000},
    {OW, 4'd2,8'h00,16'h00FF,16'h0000},
    {ORD,4'd2,8'h03,16'h0000,16'hFFFF},
    {OW, 4'd3,8'h03,16'h0040,16'h0000}, // R3
    {ORD,4'd3,8'h03,16'h0000,16'h0080},
    {OW, 4'd3,8'h03,16'h1234,16'h0000},
    {OT, 4'd3,8'h00,16'h0000,16'h0000},
    {ORD,4'd3,8'h03,16'h0000,16'h0080},
    {OW, 4'd3,8'h00,16'h00FF,16'h0000},
    {ORD,4'd3,8'h03,16'h0000,16'h1234},
    {OW, 4'd3,8'h03,16'h0040,16'h0000},
    {OW, 4'd3,8'h03,16'hFF0F,16'h0000},
    {OT, 4'd3,8'h00,16'h0000,16'h0000},
    {OW, 4'd3,8'h00,16'h00FF,16'h0000},
    {ORD,4'd3,8'h03,16'h0000,16'h1204},
    {OW, 4'd4,8'h08,16'h00E8,16'h0000}, // R4
    {OW, 4'd4,8'h08,16'h0002,16'h0000},
    {OW, 4'd4,8'h09,16'hAAAA,16'h0000},
    {OW, 4'd4,8'h0A,16'h5555,16'h0000},
    {OW, 4'd4,8'h0F,16'h0F0F,16'h0000},
    {ORD,4'd4,8'h00,16'h0000,16'h0080},
    {OW, 4'd4,8'h08,16'h00D0,16'h0000},
    {OT, 4'd4,8'h00,16'h0000,16'h0000},
    {OW, 4'd4,8'h00,16'h00FF,16'h0000},
    {ORD,4'd4,8'h09,16'h0000,16'hAAAA},
    {ORD,4'd4,8'h0A,16'h0000,16'h5555},
    {ORD,4'd4,8'h0F,16'h0000,16'h0F0F},
    {ORD,4'd4,8'h08,16'h0000,16'hFFFF},
    {OW, 4'd6,8'h0C,16'h0020,16'h0000}, // R6
    {OW, 4'd6,8'h0C,16'h00D0,16'h0000},
    {OT, 4'd6,8'h00,16'h0000,16'h0000},
    {OW, 4'd6,8'h00,16'h00FF,16'h0000},
    {ORD,4'd6,8'h09,16'h0000,16'hFFFF},
    {ORD,4'd6,8'h0F,16'h0000,16'hFFFF},
    {ORD,4'd6,8'h03,16'h0000,16'h1204},
    {OW, 4'd6,8'h10,16'h0020,16'h0000},
    {OW, 4'd6,8'h10,16'h00FF,16'h0000},
    {ORD,4'd6,8'h00,16'h0000,16'h00B0},
    {OW, 4'd10,8'h03,16'h0040,16'h0000}, // R10
    {OW, 4'd10,8'h03,16'h0000,16'h0000},
    {ORD,4'd10,8'h00,16'h0000,16'h00B0},
    {OW, 4'd9,8'h00,16'h00FF,16'h0000}, // R9
    {OW, 4'd9,8'h00,16'h0070,16'h0000},
    {ORD,4'd9,8'h00,16'h0000,16'h00B0},
    {OW, 4'd9,8'h00,16'h0050,16'h0000},
    {ORD,4'd9,8'h00,16'h0000,16'h0080},
    {OW, 4'd10,8'h00,16'h00FF,16'h0000},
    {ORD,4'd10,8'h03,16'h0000,16'h1204}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (ready !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {15'd0, ready}, 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {15'd0, ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][45:44])
        OW:  wr(AW'(VEC[i][39:32]), VEC[i][31:16]);
        ORD: rd($sformatf("R%0d", VEC[i][43:40]), AW'(VEC[i][39:32]), VEC[i][15:0]);
        default: wait_ready($sformatf("R%0d", VEC[i][43:40]));
      endcase
    end

    // R5 count too large
    wr(6'h08, 16'h00E8); wr(6'h08, 16'h0008); rd("R5", 6'h00, 16'h00B0);
    wr(6'h00, 16'h0050);
    // R5 wrong confirm word
    wr(6'h08, 16'h00E8); wr(6'h08, 16'h0000); wr(6'h09, 16'h1111); wr(6'h08, 16'h00FF);
    wr(6'h00, 16'h0070); rd("R5", 6'h00, 16'h00B0); wr(6'h00, 16'h0050);
    // R5 confirm to another block
    wr(6'h08, 16'h00E8); wr(6'h08, 16'h0000); wr(6'h09, 16'h1111); wr(6'h10, 16'h00D0);
    rd("R5", 6'h00, 16'h00B0); wr(6'h00, 16'h0050);
    // R5 data outside block
    wr(6'h08, 16'h00E8); wr(6'h08, 16'h0001); wr(6'h11, 16'h2222);
    rd("R5", 6'h00, 16'h00B0); wr(6'h00, 16'h0050);
    wr(6'h00, 16'h00FF);
    rd("R5", 6'h09, 16'hFFFF);
    rd("R5", 6'h11, 16'hFFFF);

    // R3 exact busy length
    wr(6'h18, 16'h0040); wr(6'h18, 16'h0F00);
    chk("R3", {15'd0, ready}, 16'd0);
    for (int i = 1; i < PGM; i++) begin
      @(negedge clk);
      chk("R3", {15'd0, ready}, 16'd0);
    end
    @(negedge clk);
    chk("R3", {15'd0, ready}, 16'd1);
    wr(6'h00, 16'h00FF); rd("R3", 6'h18, 16'h0F00);

    // R7 R8 program suspend and resume
    wr(6'h20, 16'h0040); wr(6'h20, 16'h00F0);
    repeat (3) @(negedge clk);
    wr(6'h00, 16'h00B0);
    #1 chk("R7", rd_data, 16'h0084);
    wr(6'h00, 16'h00FF); rd("R7", 6'h20, 16'hFFFF);
    repeat (40) @(negedge clk);
    chk("R7", {15'd0, ready}, 16'd1);
    wr(6'h00, 16'h0070); rd("R7", 6'h00, 16'h0084);
    wr(6'h00, 16'h00D0);
    #1 chk("R8", rd_data, 16'h0000);
    wait_ready("R8");
    rd("R8", 6'h00, 16'h0080);
    wr(6'h00, 16'h00FF); rd("R8", 6'h20, 16'h00F0);

    // R7 R8 erase suspend and resume
    wr(6'h20, 16'h0020); wr(6'h20, 16'h00D0);
    wr(6'h00, 16'h00B0);
    #1 chk("R7", rd_data, 16'h00C0);
    wr(6'h00, 16'h00FF); rd("R7", 6'h20, 16'h00F0);
    wr(6'h00, 16'h00D0);
    wait_ready("R8");
    rd("R8", 6'h00, 16'h0080);
    wr(6'h00, 16'h00FF);
    rd("R8", 6'h20, 16'hFFFF);
    rd("R8", 6'h27, 16'hFFFF);

    // R11 commands ignored while busy
    wr(6'h21, 16'h0040); wr(6'h21, 16'h0000);
    wr(6'h00, 16'h00FF);
    rd("R11", 6'h21, 16'h0000);
    wait_ready("R11");
    rd("R11", 6'h21, 16'h0080);
    wr(6'h00, 16'h00FF); rd("R11", 6'h21, 16'h0000);

    // R1 reset during an erase
    wr(6'h28, 16'h0020); wr(6'h28, 16'h00D0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    #1 chk("R1", {15'd0, ready}, 16'd1);
    rd("R1", 6'h21, 16'hFFFF);
    wr(6'h00, 16'h0070); rd("R1", 6'h00, 16'h0080);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule